// File: doc/BRIEF.md
# Gate-Enable Reset Sequencer with Fault Latch

This block watches a single gate-enable input and uses it to sequence the shutdown and restart of a gate-driver domain and of the auxiliary domains (charge pump, regulators, amplifiers) that sit beside it. The moment enable is seen low, the gate outputs are forced off. If enable stays low long enough, the auxiliary domains are powered down as well. When enable returns high, the length of the low period decides what kind of reset took place. A short low period is a quick reset: it clears latched faults and leaves the auxiliaries running. A long low period is a full reset: it brings every domain to its off state before restarting.

The block also owns the fault-reporting policy. Supply and gate-supply undervoltage act without latching. An overtemperature shutdown is latched. A gate-supply overvoltage is also latched, but only a full reset clears it. An overcurrent latch held by a companion block is reported here, and that companion clears it on this block's `fault_clear` pulse. A latch whose cause is still present survives any reset. An active-low fault output and an active-low warning output summarise the state.

All event inputs and `en_gate` are assumed to be synchronous to `clk`. There is no data stream, so every pin is a plain level or pulse. Timing thresholds are parameters counted in clock cycles. The defaults assume a 100 MHz clock: 10 µs is 1000 cycles and 1 µs is 100 cycles.

Top module: `gate_enable_seq`

## Requirements
- R1: In the cycle after a clock edge samples `en_gate` low, `gate_shutdown` is 1. `aux_enable` is not affected by a single low sample.
- R2: `aux_enable` goes to 0 after the clock edge that samples the `AUX_OFF_CYC`-th consecutive low value of `en_gate`. A low run of `AUX_OFF_CYC-1` samples leaves `aux_enable` at 1.
- R3: On the first high sample after a low run, the reset kind is chosen from the run length. Fewer than `AUX_OFF_CYC` low samples is a quick reset. `AUX_OFF_CYC` or more samples, including any run up to twice that length, is a full reset. Both kinds clear a latched overtemperature shutdown whose cause is gone.
- R4: A gate-supply overvoltage (`gvdd_ov` = 1 at any clock edge) latches. A quick reset leaves the latch set. Only a full reset clears it.
- R5: While `pvdd_uv` or `gvdd_uv` is 1, `gate_shutdown` = 1 and `fault_n` = 0. Both outputs return to their normal values in the cycle the condition clears, with no reset needed.
- R6: `ot_warn` = 1 drives `warn_n` to 0 and changes neither `gate_shutdown` nor `fault_n`.
- R7: `ot_sd` = 1 at a clock edge latches. After that edge, `gate_shutdown` = 1, `fault_n` = 0 and `warn_n` = 0 until a reset clears the latch.
- R8: `oc_latched` = 1 drives `fault_n` and `warn_n` to 0 and does not assert `gate_shutdown`.
- R9: After the clock edge that first samples `en_gate` high, `gate_shutdown` stays 1 for `PWRUP_CYC` further edges and is 0 after the `PWRUP_CYC`-th. `fault_n` stays 0 until then, because the gate driver is not yet ready.
- R10: A latch whose cause input is still 1 when a reset is applied stays set.
- R11: `fault_clear` is a single-cycle pulse. It is 1 in the cycle right after the edge that samples `en_gate` high following a low run (quick or full), and 0 in the cycle after that.
- R12: During reset (`rst_n` = 0) with all event inputs at 0: `gate_shutdown` = 1, `aux_enable` = 0, `fault_clear` = 0, `fault_n` = 0, `warn_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_gate | input | 1 | Gate enable; low periods are timed and classified as resets |
| pvdd_uv | input | 1 | Power supply undervoltage flag (not latched) |
| gvdd_uv | input | 1 | Gate supply undervoltage flag (not latched) |
| gvdd_ov | input | 1 | Gate supply overvoltage flag (latched, cleared by full reset only) |
| ot_warn | input | 1 | Overtemperature warning flag |
| ot_sd | input | 1 | Overtemperature shutdown flag (latched) |
| oc_latched | input | 1 | Overcurrent latch held by a companion block |
| gate_shutdown | output | 1 | 1 forces all gate outputs off |
| aux_enable | output | 1 | 1 keeps the auxiliary domains powered |
| fault_clear | output | 1 | One-cycle pulse when a reset is applied |
| fault_n | output | 1 | Active-low fault indication |
| warn_n | output | 1 | Active-low warning indication |

## Verification
The bench targets the boundary of the low-period classification. A run one sample short of the threshold must keep the auxiliaries on, and a run exactly at the threshold must drop them. A design that is off by one there would either power down on a quick reset or let a long pulse pass as quick. It also places a low pulse inside the window between one and two thresholds. A design that left that window undefined would not report it as a full reset. Further cases check that a quick reset cannot clear the overvoltage latch, that a latch with its cause still present survives a reset, and that the power-up delay ends on exactly the right edge. A design that cleared these too eagerly, or released the gates early, would show a wrong `fault_n` or `gate_shutdown` at those sample points.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF     = 2'd0,
    SEQ_PWRUP   = 2'd1,
    SEQ_RUN     = 2'd2,
    SEQ_LOWHOLD = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    RST_NONE  = 2'd0,
    RST_QUICK = 2'd1,
    RST_FULL  = 2'd2
  } rst_kind_e;

  localparam int LATCH_OTSD = 0;
  localparam int LATCH_OVGS = 1;
  localparam int NUM_LATCH  = 2;

endpackage

// File: rtl/gseq_ctrl.sv
module gseq_ctrl
  import gseq_pkg::*;
#(
  parameter int AUX_OFF_CYC = 1000,
  parameter int PWRUP_CYC   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_gate,
  output seq_state_e state,
  output rst_kind_e  rst_kind,
  output logic       clear_pulse
);

  localparam int LOW_W = $clog2(AUX_OFF_CYC + 1);
  localparam int PU_W  = $clog2(PWRUP_CYC + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(AUX_OFF_CYC - 1);
  localparam logic [PU_W-1:0]  PU_LAST  = PU_W'(PWRUP_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [LOW_W-1:0] low_cnt_q, low_cnt_d;
  logic [PU_W-1:0]  pu_cnt_q, pu_cnt_d;
  logic             pulse_q;

  // low_cnt_q holds the number of consecutive low samples seen so far
  always_comb begin
    state_d   = state_q;
    low_cnt_d = low_cnt_q;
    pu_cnt_d  = pu_cnt_q;
    rst_kind  = RST_NONE;
    unique case (state_q)
      SEQ_OFF: begin
        if (en_gate) begin
          state_d  = SEQ_PWRUP;
          pu_cnt_d = '0;
          rst_kind = RST_FULL;
        end
      end
      SEQ_PWRUP: begin
        if (!en_gate) begin
          state_d   = SEQ_LOWHOLD;
          low_cnt_d = LOW_W'(1);
        end else if (pu_cnt_q == PU_LAST) begin
          state_d = SEQ_RUN;
        end else begin
          pu_cnt_d = pu_cnt_q + PU_W'(1);
        end
      end
      SEQ_RUN: begin
        if (!en_gate) begin
          state_d   = SEQ_LOWHOLD;
          low_cnt_d = LOW_W'(1);
        end
      end
      SEQ_LOWHOLD: begin
        if (en_gate) begin
          state_d  = SEQ_PWRUP;
          pu_cnt_d = '0;
          rst_kind = RST_QUICK;
        end else if (low_cnt_q >= LOW_LAST) begin
          state_d = SEQ_OFF;
        end else begin
          low_cnt_d = low_cnt_q + LOW_W'(1);
        end
      end
      default: state_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_OFF;
      low_cnt_q <= '0;
      pu_cnt_q  <= '0;
      pulse_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      low_cnt_q <= low_cnt_d;
      pu_cnt_q  <= pu_cnt_d;
      pulse_q   <= (rst_kind != RST_NONE);
    end
  end

  assign state       = state_q;
  assign clear_pulse = pulse_q;

endmodule

// File: rtl/gseq_latch_bank.sv
module gseq_latch_bank #(
  parameter int             NUM       = 2,
  parameter logic [NUM-1:0] FULL_ONLY = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_evt,
  input  logic           clr_quick,
  input  logic           clr_full,
  output logic [NUM-1:0] held
);

  for (genvar i = 0; i < NUM; i++) begin : g_lat
    logic lat_q;
    logic clr_ok;

    if (FULL_ONLY[i]) begin : g_full
      assign clr_ok = clr_full;
    end else begin : g_any
      assign clr_ok = clr_quick | clr_full;
    end

    // a present cause re-sets the latch in the same edge that would clear it
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= 1'b0;
      else        lat_q <= (lat_q & ~clr_ok) | set_evt[i];
    end

    assign held[i] = lat_q;
  end

endmodule

// File: rtl/gseq_report.sv
module gseq_report
  import gseq_pkg::*;
(
  input  seq_state_e           state,
  input  logic                 pvdd_uv,
  input  logic                 gvdd_uv,
  input  logic                 ot_warn,
  input  logic                 oc_latched,
  input  logic [NUM_LATCH-1:0] held,
  output logic                 gate_shutdown,
  output logic                 aux_enable,
  output logic                 fault_n,
  output logic                 warn_n
);

  logic ready;
  logic uv_any;
  logic shut_latch;

  assign ready      = (state == SEQ_RUN);
  assign uv_any     = pvdd_uv | gvdd_uv;
  assign shut_latch = held[LATCH_OTSD] | held[LATCH_OVGS];

  assign gate_shutdown = !ready || uv_any || shut_latch;
  assign aux_enable    = (state != SEQ_OFF);
  assign fault_n       = ready && !uv_any && !shut_latch && !oc_latched;
  assign warn_n        = !(ot_warn || held[LATCH_OTSD] || oc_latched);

endmodule

// File: rtl/gate_enable_seq.sv
module gate_enable_seq
  import gseq_pkg::*;
#(
  parameter int AUX_OFF_CYC = 1000,
  parameter int PWRUP_CYC   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_gate,
  input  logic pvdd_uv,
  input  logic gvdd_uv,
  input  logic gvdd_ov,
  input  logic ot_warn,
  input  logic ot_sd,
  input  logic oc_latched,
  output logic gate_shutdown,
  output logic aux_enable,
  output logic fault_clear,
  output logic fault_n,
  output logic warn_n
);

  localparam logic [NUM_LATCH-1:0] FULL_ONLY_MASK = NUM_LATCH'(1 << LATCH_OVGS);

  seq_state_e           state;
  rst_kind_e            rst_kind;
  logic [NUM_LATCH-1:0] set_evt;
  logic [NUM_LATCH-1:0] held;

  gseq_ctrl #(
    .AUX_OFF_CYC(AUX_OFF_CYC),
    .PWRUP_CYC  (PWRUP_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_gate    (en_gate),
    .state      (state),
    .rst_kind   (rst_kind),
    .clear_pulse(fault_clear)
  );

  always_comb begin
    set_evt             = '0;
    set_evt[LATCH_OTSD] = ot_sd;
    set_evt[LATCH_OVGS] = gvdd_ov;
  end

  gseq_latch_bank #(
    .NUM      (NUM_LATCH),
    .FULL_ONLY(FULL_ONLY_MASK)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .clr_quick(rst_kind == RST_QUICK),
    .clr_full (rst_kind == RST_FULL),
    .held     (held)
  );

  gseq_report u_report (
    .state        (state),
    .pvdd_uv      (pvdd_uv),
    .gvdd_uv      (gvdd_uv),
    .ot_warn      (ot_warn),
    .oc_latched   (oc_latched),
    .held         (held),
    .gate_shutdown(gate_shutdown),
    .aux_enable   (aux_enable),
    .fault_n      (fault_n),
    .warn_n       (warn_n)
  );

endmodule

// File: rtl/gseq_checker.sv
module gseq_checker #(
  parameter int AUX_OFF_CYC = 1000,
  parameter int PWRUP_CYC   = 100
) (
  input logic clk,
  input logic rst_n,
  input logic en_gate,
  input logic pvdd_uv,
  input logic gvdd_uv,
  input logic gvdd_ov,
  input logic ot_warn,
  input logic ot_sd,
  input logic oc_latched,
  input logic gate_shutdown,
  input logic aux_enable,
  input logic fault_clear,
  input logic fault_n,
  input logic warn_n
);

  logic [31:0] low_run;
  logic [31:0] hi_run;

  // consecutive low / high samples of the enable, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      hi_run  <= '0;
    end else begin
      low_run <= en_gate ? 32'd0 : ((low_run == '1) ? low_run : low_run + 32'd1);
      hi_run  <= !en_gate ? 32'd0 : ((hi_run == '1) ? hi_run : hi_run + 32'd1);
    end
  end

  assert_low_forces_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_gate |=> gate_shutdown);

  assert_aux_drop_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aux_enable) |-> (low_run >= 32'(AUX_OFF_CYC)));

  assert_aux_off_means_gates_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_enable |-> gate_shutdown);

  assert_ov_reports_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gvdd_ov |=> !fault_n && gate_shutdown);

  assert_uv_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pvdd_uv || gvdd_uv) |-> gate_shutdown && !fault_n);

  assert_warn_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ot_warn |-> !warn_n);

  assert_otsd_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ot_sd |=> gate_shutdown && !fault_n && !warn_n);

  assert_oc_reports_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oc_latched |-> !fault_n && !warn_n);

  assert_pwrup_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_shutdown) |-> (hi_run >= 32'(PWRUP_CYC + 1)));

  assert_clear_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clear |=> !fault_clear);

  assert_clear_context_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clear |-> aux_enable && gate_shutdown && en_gate);

endmodule

bind gate_enable_seq gseq_checker #(
  .AUX_OFF_CYC(AUX_OFF_CYC),
  .PWRUP_CYC  (PWRUP_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_gate      (en_gate),
  .pvdd_uv      (pvdd_uv),
  .gvdd_uv      (gvdd_uv),
  .gvdd_ov      (gvdd_ov),
  .ot_warn      (ot_warn),
  .ot_sd        (ot_sd),
  .oc_latched   (oc_latched),
  .gate_shutdown(gate_shutdown),
  .aux_enable   (aux_enable),
  .fault_clear  (fault_clear),
  .fault_n      (fault_n),
  .warn_n       (warn_n)
);

// File: tb/gate_enable_seq_tb.sv
module gate_enable_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AUX_CYC    = 40;
  localparam int PU_CYC     = 6;
  localparam int NVEC       = 9;

  // {pvdd_uv, gvdd_uv, ot_warn, oc_latched, exp_gate_sd, exp_fault_n, exp_warn_n}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0000_011, 7'b1000_101, 7'b0100_101, 7'b0010_010, 7'b0001_000,
    7'b1010_100, 7'b0101_100, 7'b1100_101, 7'b0000_011
  };

  logic clk = 1'b0;
  logic rst_n, en_gate, pvdd_uv, gvdd_uv, gvdd_ov, ot_warn, ot_sd, oc_latched;
  logic gate_shutdown, aux_enable, fault_clear, fault_n, warn_n;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_enable_seq #(.AUX_OFF_CYC(AUX_CYC), .PWRUP_CYC(PU_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_gate(en_gate), .pvdd_uv(pvdd_uv),
    .gvdd_uv(gvdd_uv), .gvdd_ov(gvdd_ov), .ot_warn(ot_warn), .ot_sd(ot_sd),
    .oc_latched(oc_latched), .gate_shutdown(gate_shutdown),
    .aux_enable(aux_enable), .fault_clear(fault_clear), .fault_n(fault_n),
    .warn_n(warn_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // hold enable low for n sampling edges, end just after a falling clock edge
  task automatic hold_low(input int n);
    @(negedge clk) en_gate = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // raise enable and wait until the power-up delay has elapsed
  task automatic bring_up();
    en_gate = 1'b1;
    repeat (PU_CYC + 1) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_gate = 1'b0; pvdd_uv = 1'b0; gvdd_uv = 1'b0;
    gvdd_ov = 1'b0; ot_warn = 1'b0; ot_sd = 1'b0; oc_latched = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 gate_shutdown", gate_shutdown, 1'b1);
    chk("R12 aux_enable", aux_enable, 1'b0);
    chk("R12 fault_clear", fault_clear, 1'b0);
    chk("R12 fault_n", fault_n, 1'b0);
    chk("R12 warn_n", warn_n, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R9 / R11: power-up from off
    @(negedge clk) en_gate = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 clear pulse on power-up", fault_clear, 1'b1);
    chk("R9 gates held at start", gate_shutdown, 1'b1);
    chk("R9 fault_n not ready", fault_n, 1'b0);
    chk("R2 aux on at power-up", aux_enable, 1'b1);
    repeat (PU_CYC - 1) @(posedge clk);
    @(negedge clk);
    chk("R9 gates still held one edge early", gate_shutdown, 1'b1);
    chk("R11 clear pulse single cycle", fault_clear, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 gates released", gate_shutdown, 1'b0);
    chk("R9 fault_n ready", fault_n, 1'b1);

    // R5 / R6 / R8: vector table in run state
    for (int i = 0; i < NVEC; i++) begin
      {pvdd_uv, gvdd_uv, ot_warn, oc_latched} = VEC[i][6:3];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R5/R6/R8 vec%0d gate_shutdown", i), gate_shutdown, VEC[i][2]);
      chk($sformatf("R5/R6/R8 vec%0d fault_n", i), fault_n, VEC[i][1]);
      chk($sformatf("R5/R6/R8 vec%0d warn_n", i), warn_n, VEC[i][0]);
    end

    // R1 / R2 / R3: low run one short of the threshold is quick
    hold_low(1);
    chk("R1 gates off after one low sample", gate_shutdown, 1'b1);
    chk("R1 aux kept", aux_enable, 1'b1);
    repeat (AUX_CYC - 2) @(posedge clk);
    @(negedge clk);
    chk("R2 aux kept at threshold-1", aux_enable, 1'b1);
    en_gate = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 clear pulse on quick reset", fault_clear, 1'b1);
    chk("R3 quick reset keeps aux", aux_enable, 1'b1);
    repeat (PU_CYC) @(posedge clk);
    @(negedge clk);
    chk("R9 gates released after quick", gate_shutdown, 1'b0);

    // R2: exactly the threshold drops aux
    hold_low(AUX_CYC);
    chk("R2 aux off at threshold", aux_enable, 1'b0);
    bring_up();
    chk("R3 running after full", gate_shutdown, 1'b0);

    // R7 / R3: overtemperature shutdown latched, cleared by quick reset
    @(negedge clk) ot_sd = 1'b1;
    @(negedge clk) ot_sd = 1'b0;
    @(negedge clk);
    chk("R7 gates off latched", gate_shutdown, 1'b1);
    chk("R7 fault_n latched", fault_n, 1'b0);
    chk("R7 warn_n latched", warn_n, 1'b0);
    hold_low(5);
    bring_up();
    chk("R3 quick clears otsd gate", gate_shutdown, 1'b0);
    chk("R3 quick clears otsd fault", fault_n, 1'b1);
    chk("R3 quick clears otsd warn", warn_n, 1'b1);

    // R4: overvoltage survives quick reset, cleared by full (window pulse)
    @(negedge clk) gvdd_ov = 1'b1;
    @(negedge clk) gvdd_ov = 1'b0;
    @(negedge clk);
    chk("R4 ov latched", fault_n, 1'b0);
    hold_low(5);
    bring_up();
    chk("R4 ov kept by quick reset fault_n", fault_n, 1'b0);
    chk("R4 ov kept by quick reset gates", gate_shutdown, 1'b1);
    hold_low(AUX_CYC + AUX_CYC/2);
    chk("R3 window pulse is full (aux off)", aux_enable, 1'b0);
    bring_up();
    chk("R4 full reset clears ov", fault_n, 1'b1);
    chk("R4 full reset releases gates", gate_shutdown, 1'b0);

    // R10: cause present at reset keeps latch
    @(negedge clk) ot_sd = 1'b1;
    hold_low(5);
    bring_up();
    chk("R10 otsd kept while present", fault_n, 1'b0);
    @(negedge clk) ot_sd = 1'b0;
    @(negedge clk);
    chk("R10 latch holds after cause gone", gate_shutdown, 1'b1);
    hold_low(5);
    bring_up();
    chk("R10 cleared by later reset", fault_n, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule